// File: doc/BRIEF.md
# SPI Master Controller with Buffered Full-Duplex Transfers

This block is a register-programmed SPI master. Software fills an internal transmit byte buffer over a simple word-addressed bus, sets a character count and writes the start bit of the command register. The controller then shifts that many characters out on MOSI, captures the same number of characters from MISO (or from its own MOSI in loopback), and stores each received character into an internal receive byte buffer at the same index. A receive count register reports how many characters actually arrived.

A mode register selects the character length (1 to 8 bits), the bit order, the SCK idle level, the clock phase, a prescaler with an optional divide-by-16 stage, loopback, master operation and enable. Completion and error conditions are recorded in a sticky event register with write-one-to-clear semantics, and any event whose mask bit is set drives the interrupt output. A low level on the slave-select sense input while the controller is an enabled master is treated as a bus conflict from another master.

Register map (word addresses): 0x00 mode, 0x01 events, 0x02 event mask, 0x03 command, 0x04 transmit count, 0x05 receive count, 0x40+i transmit buffer byte i, 0x80+i receive buffer byte i.

Top module: `spi_host_ctl`

## Requirements
- R1: After reset every register reads 0, sck_o and irq_o are 0; mode (0x00), mask (0x02, bits 5:0), transmit count (0x04) and transmit buffer bytes (0x40+i, low 8 bits) read back what was written.
- R2: Writing 0x03 with bit 7 set while idle, with mode bit 8 (enable) and bit 9 (master) set and a transmit count of 1..64, transfers that many characters; received character i is stored at 0x80+i, 0x05 then reads the count, and event bits 1 (transmit done) and 0 (receive done) are set.
- R3: Character length is mode[7:4]+1 bits, with field values above 7 treated as 8; each character uses the low bits of its byte and the received byte has its upper bits zero.
- R4: Mode bit 10 set sends and receives the most significant bit of each character first; clear sends and receives the least significant bit first.
- R5: SCK idles at the level of mode bit 13; each SCK half period lasts (mode[3:0]+1) clock cycles, multiplied by 16 when mode bit 11 is set.
- R6: With mode bit 12 clear, MOSI is valid before the first edge of each bit and MISO is sampled on the first edge; with it set, MOSI changes on the first edge and MISO is sampled on the second.
- R7: With mode bit 14 set, received data is taken from the controller's own MOSI and miso_i is ignored.
- R8: A start write during a transfer sets event bit 2 and leaves the running transfer unchanged.
- R9: A start with a transmit count above 64 sets event bit 4 and produces no SCK edge; a count of 0 sets event bits 1 and 0 at once with receive count 0.
- R10: Event bits stay set until a 1 is written to them at 0x01; irq_o is high exactly when some event bit and its mask bit are both set.
- R11: Clearing the enable bit during a transfer stops it: SCK returns to idle, no completion event is raised, 0x05 holds the characters finished so far, and the next start begins at buffer index 0.
- R12: ss_ni low while enabled as master sets event bit 5 and aborts any transfer.
- R13: A start while the master or enable bit is clear does nothing: no event and no SCK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Bus write enable |
| addr_i | input | 8 | Bus word address |
| wdata_i | input | 16 | Bus write data |
| rdata_o | output | 16 | Bus read data (combinational from addr_i) |
| irq_o | output | 1 | Masked event interrupt |
| sck_o | output | 1 | SPI clock |
| mosi_o | output | 1 | SPI data out |
| miso_i | input | 1 | SPI data in |
| ss_ni | input | 1 | Slave-select sense, low means another master drives the bus |

## Verification
The bench tracks every SCK edge like an attached slave, records MOSI on the sample edge for the programmed phase, and rebuilds each character, so a design with a swapped bit order, a wrong length clamp or the wrong sampling edge shows a mismatched stream or edge count. With miso_i tied to the inverse of mosi_o, a loopback select that still listens to the pin returns inverted bytes instead of the sent ones. The half-period measurement catches a prescaler that is off by one or ignores the divide-by-16 stage. Aborts by enable clear and by slave-select conflict are followed by a full transfer, which exposes a byte counter that is not reset or an SCK left at the wrong level; a double start, a count of 65 and a count of 0 target the busy, error and empty-transfer paths.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_FINISH} seq_state_e;

  localparam int M_LOOP   = 14;
  localparam int M_CPOL   = 13;
  localparam int M_CPHA   = 12;
  localparam int M_DIV16  = 11;
  localparam int M_MSB    = 10;
  localparam int M_MASTER = 9;
  localparam int M_EN     = 8;

  localparam int EV_RXB = 0;
  localparam int EV_TXB = 1;
  localparam int EV_BSY = 2;
  localparam int EV_TXE = 4;
  localparam int EV_MME = 5;
  localparam logic [5:0] EV_IMPL = 6'b110111;

  localparam int CMD_START = 7;

  localparam logic [7:0] A_MODE = 8'h00;
  localparam logic [7:0] A_EV   = 8'h01;
  localparam logic [7:0] A_MASK = 8'h02;
  localparam logic [7:0] A_CMD  = 8'h03;
  localparam logic [7:0] A_TXC  = 8'h04;
  localparam logic [7:0] A_RXC  = 8'h05;
  localparam logic [1:0] A_TXBUF = 2'b01;
  localparam logic [1:0] A_RXBUF = 2'b10;
endpackage

// File: rtl/spi_byte_mem.sv
module spi_byte_mem #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [7:0]       wdata_i,
  input  logic [IDX_W-1:0] raddr_a_i,
  output logic [7:0]       rdata_a_o,
  input  logic [IDX_W-1:0] raddr_b_i,
  output logic [7:0]       rdata_b_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/spi_sck_tick.sv
module spi_sck_tick #(
  parameter int PRE_W = 4,
  parameter int DIV   = 16,
  localparam int DW = $clog2(DIV)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             div_en_i,
  input  logic [PRE_W-1:0] presc_i,
  output logic             tick_o
);
  logic [DW-1:0]    dcnt_q;
  logic [PRE_W-1:0] pcnt_q;
  logic             base;

  assign base   = !div_en_i || (dcnt_q == DW'(DIV - 1));
  assign tick_o = !clear_i && base && (pcnt_q == presc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dcnt_q <= '0;
      pcnt_q <= '0;
    end else if (clear_i) begin
      dcnt_q <= '0;
      pcnt_q <= '0;
    end else begin
      dcnt_q <= dcnt_q + 1'b1;
      if (base) pcnt_q <= tick_o ? '0 : pcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/spi_char_shifter.sv
module spi_char_shifter (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       load_i,
  input  logic [7:0] tx_byte_i,
  input  logic [2:0] last_i,     // character bits minus one
  input  logic       msb_first_i,
  input  logic       cpha_i,
  input  logic       tick_i,
  input  logic       miso_i,
  output logic       mosi_o,
  output logic       tog_o,
  output logic       done_o,
  output logic [7:0] rx_byte_o
);
  logic       active_q, half_q, mosi_q, tog_q, done_q;
  logic [2:0] idx_q;
  logic [7:0] txb_q, rxb_q;

  function automatic logic [2:0] pos(input logic [2:0] i, input logic [2:0] last, input logic msb);
    return msb ? last - i : i;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0; half_q <= 1'b0; mosi_q <= 1'b0; tog_q <= 1'b0;
      done_q <= 1'b0; idx_q <= '0; txb_q <= '0; rxb_q <= '0;
    end else if (clear_i) begin
      active_q <= 1'b0; half_q <= 1'b0; tog_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_i) begin
        active_q <= 1'b1;
        half_q   <= 1'b0;
        idx_q    <= '0;
        tog_q    <= 1'b0;
        txb_q    <= tx_byte_i;
        rxb_q    <= '0;
        if (!cpha_i) mosi_q <= tx_byte_i[pos(3'd0, last_i, msb_first_i)];
      end else if (tick_i && active_q) begin
        tog_q <= !tog_q;
        if (!half_q) begin
          half_q <= 1'b1;
          if (cpha_i) mosi_q <= txb_q[pos(idx_q, last_i, msb_first_i)];
          else        rxb_q[pos(idx_q, last_i, msb_first_i)] <= miso_i;
        end else begin
          half_q <= 1'b0;
          if (cpha_i) rxb_q[pos(idx_q, last_i, msb_first_i)] <= miso_i;
          if (idx_q == last_i) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
            if (!cpha_i) mosi_q <= txb_q[pos(idx_q + 1'b1, last_i, msb_first_i)];
          end
        end
      end
    end
  end

  assign mosi_o    = mosi_q;
  assign tog_o     = tog_q;
  assign done_o    = done_q;
  assign rx_byte_o = rxb_q;
endmodule

// File: rtl/spi_host_ctl.sv
module spi_host_ctl
  import spi_host_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        irq_o,
  output logic        sck_o,
  output logic        mosi_o,
  input  logic        miso_i,
  input  logic        ss_ni
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  seq_state_e       state_q;
  logic [15:0]      mode_q;
  logic [5:0]       ev_q, mask_q, ev_set, ev_clr;
  logic [CNT_W-1:0] tx_cnt_q, rx_len_q, byte_cnt_q;
  logic             wr, start_wr, ev_wr, busy, mme_hit, abort, accept;
  logic             tick, sh_done, sh_tog, sh_mosi, miso_eff, rx_we;
  logic [7:0]       tx_byte, tx_rb, rx_rb, sh_rx;
  logic [2:0]       last_bit;

  assign wr       = req_i && we_i;
  assign start_wr = wr && (addr_i == A_CMD) && wdata_i[CMD_START];
  assign ev_wr    = wr && (addr_i == A_EV);
  assign busy     = (state_q != ST_IDLE);
  assign mme_hit  = mode_q[M_EN] && mode_q[M_MASTER] && !ss_ni;
  assign abort    = busy && (!mode_q[M_EN] || mme_hit);
  assign accept   = start_wr && !busy && mode_q[M_EN] && mode_q[M_MASTER] && !mme_hit;
  assign last_bit = mode_q[7] ? 3'd7 : mode_q[6:4];
  assign miso_eff = mode_q[M_LOOP] ? sh_mosi : miso_i;
  assign rx_we    = (state_q == ST_SHIFT) && sh_done && !abort;

  always_comb begin
    ev_set = '0;
    ev_set[EV_BSY] = start_wr && busy;
    ev_set[EV_TXE] = accept && (tx_cnt_q > DEPTH_C);
    ev_set[EV_MME] = mme_hit;
    ev_set[EV_TXB] = (state_q == ST_FINISH) && !abort;
    ev_set[EV_RXB] = (state_q == ST_FINISH) && !abort;
    ev_clr = ev_wr ? wdata_i[5:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      mode_q     <= '0;
      ev_q       <= '0;
      mask_q     <= '0;
      tx_cnt_q   <= '0;
      rx_len_q   <= '0;
      byte_cnt_q <= '0;
    end else begin
      if (wr && addr_i == A_MODE) mode_q   <= wdata_i;
      if (wr && addr_i == A_MASK) mask_q   <= wdata_i[5:0];
      if (wr && addr_i == A_TXC)  tx_cnt_q <= wdata_i[CNT_W-1:0];
      ev_q <= ((ev_q & ~ev_clr) | ev_set) & EV_IMPL;

      if (abort) begin
        state_q    <= ST_IDLE;
        byte_cnt_q <= '0;
      end else begin
        unique case (state_q)
          ST_IDLE: if (accept && tx_cnt_q <= DEPTH_C) begin
            rx_len_q   <= '0;
            byte_cnt_q <= '0;
            state_q    <= (tx_cnt_q == '0) ? ST_FINISH : ST_LOAD;
          end
          ST_LOAD: state_q <= ST_SHIFT;
          ST_SHIFT: if (sh_done) begin
            rx_len_q <= byte_cnt_q + 1'b1;
            if ((byte_cnt_q + 1'b1) == tx_cnt_q) begin
              state_q    <= ST_FINISH;
              byte_cnt_q <= '0;
            end else begin
              byte_cnt_q <= byte_cnt_q + 1'b1;
              state_q    <= ST_LOAD;
            end
          end
          ST_FINISH: state_q <= ST_IDLE;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  spi_byte_mem #(.DEPTH(DEPTH)) u_txbuf (
    .clk_i, .we_i(wr && addr_i[7:6] == A_TXBUF), .waddr_i(addr_i[IDX_W-1:0]),
    .wdata_i(wdata_i[7:0]), .raddr_a_i(byte_cnt_q[IDX_W-1:0]), .rdata_a_o(tx_byte),
    .raddr_b_i(addr_i[IDX_W-1:0]), .rdata_b_o(tx_rb)
  );

  logic [7:0] rx_unused;
  spi_byte_mem #(.DEPTH(DEPTH)) u_rxbuf (
    .clk_i, .we_i(rx_we), .waddr_i(byte_cnt_q[IDX_W-1:0]), .wdata_i(sh_rx),
    .raddr_a_i(byte_cnt_q[IDX_W-1:0]), .rdata_a_o(rx_unused),
    .raddr_b_i(addr_i[IDX_W-1:0]), .rdata_b_o(rx_rb)
  );

  spi_sck_tick #(.PRE_W(4), .DIV(16)) u_tick (
    .clk_i, .rst_ni, .clear_i(state_q != ST_SHIFT || abort),
    .div_en_i(mode_q[M_DIV16]), .presc_i(mode_q[3:0]), .tick_o(tick)
  );

  spi_char_shifter u_shift (
    .clk_i, .rst_ni, .clear_i(abort || state_q == ST_IDLE || state_q == ST_FINISH),
    .load_i(state_q == ST_LOAD), .tx_byte_i(tx_byte), .last_i(last_bit),
    .msb_first_i(mode_q[M_MSB]), .cpha_i(mode_q[M_CPHA]), .tick_i(tick),
    .miso_i(miso_eff), .mosi_o(sh_mosi), .tog_o(sh_tog), .done_o(sh_done), .rx_byte_o(sh_rx)
  );

  assign sck_o  = mode_q[M_CPOL] ^ sh_tog;
  assign mosi_o = sh_mosi;
  assign irq_o  = |(ev_q & mask_q);

  always_comb begin
    rdata_o = '0;
    if (addr_i[7:6] == A_TXBUF)      rdata_o = {8'h00, tx_rb};
    else if (addr_i[7:6] == A_RXBUF) rdata_o = {8'h00, rx_rb};
    else begin
      unique case (addr_i)
        A_MODE:  rdata_o = mode_q;
        A_EV:    rdata_o = {10'b0, ev_q};
        A_MASK:  rdata_o = {10'b0, mask_q};
        A_TXC:   rdata_o = 16'(tx_cnt_q);
        A_RXC:   rdata_o = 16'(rx_len_q);
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

module spi_host_ctl_chk #(
  parameter int CNT_W = 7,
  parameter int DEPTH = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_i,
  input logic [15:0]      mode_i,
  input logic [5:0]       ev_i,
  input logic             ev_wr_i,
  input logic             start_wr_i,
  input logic             sck_i,
  input logic             irq_i,
  input logic             ss_ni,
  input logic [CNT_W-1:0] rx_len_i
);
  // R5: no clock activity outside a transfer
  p_sck_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> sck_i == mode_i[13]);
  // R10: events are sticky unless the event register is written
  p_ev_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ev_wr_i |=> (ev_i & $past(ev_i)) == $past(ev_i));
  p_irq_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> ev_i != 6'd0);
  p_bsy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_wr_i && busy_i && !ev_wr_i) |=> ev_i[2]);
  p_abort_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !mode_i[8]) |=> !busy_i);
  p_mme_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[8] && mode_i[9] && !ss_ni && !ev_wr_i) |=> ev_i[5] && !busy_i);
  p_rxlen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_len_i <= CNT_W'(DEPTH));
endmodule

bind spi_host_ctl spi_host_ctl_chk #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy), .mode_i(mode_q), .ev_i(ev_q),
  .ev_wr_i(ev_wr), .start_wr_i(start_wr), .sck_i(sck_o), .irq_i(irq_o),
  .ss_ni(ss_ni), .rx_len_i(rx_len_q)
);

// File: tb/spi_host_ctl_test.sv
`timescale 1ns/1ps
module spi_host_ctl_test;
  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0, ss_n = 1;
  logic [7:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic irq, sck, mosi, miso;
  logic miso_inv = 1, miso_const = 0;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  assign miso = miso_inv ? ~mosi : miso_const;

  spi_host_ctl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .sck_o(sck),
    .mosi_o(mosi), .miso_i(miso), .ss_ni(ss_n)
  );

  // slave-side edge monitor
  longint cyc = 0, e0 = 0, e1 = 0;
  logic cpol_b = 0, cpha_b = 0, sck_prev = 0;
  logic cap [1024];
  int cap_n = 0, edge_n = 0;
  always @(posedge clk) cyc++;
  always @(negedge clk) begin
    if (sck !== sck_prev) begin
      if (((sck_prev == cpol_b) ^ cpha_b) && cap_n < 1024) begin
        cap[cap_n] = mosi;
        cap_n++;
      end
      if (edge_n == 0) e0 = cyc;
      if (edge_n == 1) e1 = cyc;
      edge_n++;
    end
    sck_prev = sck;
  end

  task automatic check(input bit ok, input string req_s, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req_s, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  function automatic int nbits(input logic [3:0] lf);
    return (lf > 7) ? 8 : int'(lf) + 1;
  endfunction

  function automatic logic [7:0] exp_rx(input logic [7:0] tx, input logic [3:0] lf, input bit loop, input bit inv, input bit cst);
    logic [7:0] m = 8'((9'd1 << nbits(lf)) - 9'd1);
    if (loop || !inv == 0) return (loop ? tx : ~tx) & m;
    return cst ? m : 8'h00;
  endfunction

  // wire-order view: first bit sent ends up most significant
  function automatic logic [7:0] exp_stream(input logic [7:0] tx, input logic [3:0] lf, input bit msb);
    logic [7:0] v = 0;
    int b = nbits(lf);
    for (int k = 0; k < b; k++) v = {v[6:0], msb ? tx[b-1-k] : tx[k]};
    return v;
  endfunction

  function automatic logic [15:0] mode_word(input bit loop, cpol, cpha, dv, msb, master, en,
                                             input logic [3:0] lf, input logic [3:0] p);
    return {1'b0, loop, cpol, cpha, dv, msb, master, en, lf, p};
  endfunction

  task automatic wait_rxb(input int limit, output bit got);
    logic [15:0] d;
    got = 0;
    for (int i = 0; i < limit; i++) begin
      rd(8'h01, d);
      if (d[0]) begin got = 1; break; end
    end
  endtask

  task automatic setup_mode(input logic [15:0] m);
    cpol_b = m[13]; cpha_b = m[12];
    wr(8'h00, m);
    @(negedge clk); @(negedge clk);
    cap_n = 0; edge_n = 0;
  endtask

  task automatic do_xfer(input bit loop, cpol, cpha, dv, msb, input logic [3:0] lf,
                         input logic [3:0] p, input int n, input bit dbl);
    logic [7:0] txd [64];
    logic [15:0] d;
    bit got;
    int b = nbits(lf);
    setup_mode(mode_word(loop, cpol, cpha, dv, msb, 1, 1, lf, p));
    wr(8'h01, 16'h003f);
    for (int i = 0; i < n; i++) begin
      txd[i] = 8'($urandom);
      wr(8'h40 + 8'(i), {8'h00, txd[i]});
    end
    wr(8'h04, 16'(n));
    wr(8'h03, 16'h0080);
    if (dbl) begin
      wr(8'h03, 16'h0080);
      rd(8'h01, d);
      check(d[2] == 1'b1, "R8 busy event on second start", d, 16'h4);
    end
    wait_rxb(20000, got);
    check(got, "R2 transfer completes", got, 1);
    rd(8'h01, d);
    check(d[1:0] == 2'b11, "R2 done events", d[1:0], 2'b11);
    rd(8'h05, d);
    check(d == 16'(n), "R2 receive count", d, n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] e = exp_rx(txd[i], lf, loop, miso_inv, miso_const);
      rd(8'h80 + 8'(i), d);
      check(d == {8'h00, e}, loop ? "R7 loopback rx byte" : "R3 rx byte", d, e);
    end
    check(edge_n == 2 * n * b, "R6 SCK edge count", edge_n, 2 * n * b);
    for (int c = 0; c < n && cap_n >= n * b; c++) begin
      logic [7:0] v = 0;
      for (int k = 0; k < b; k++) v = {v[6:0], cap[c * b + k]};
      check(v == exp_stream(txd[c], lf, msb), "R4 MOSI bit order", v, exp_stream(txd[c], lf, msb));
    end
    check((e1 - e0) == longint'((int'(p) + 1) * (dv ? 16 : 1)), "R5 half period",
          e1 - e0, (int'(p) + 1) * (dv ? 16 : 1));
    check(sck == cpol, "R5 SCK idle after transfer", sck, cpol);
  endtask

  initial begin
    logic [15:0] d;
    bit got;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check(sck == 1'b0 && irq == 1'b0, "R1 reset pins", {sck, irq}, 0);
    rst_n = 1;
    rd(8'h00, d); check(d == 16'h0, "R1 reset mode", d, 0);
    rd(8'h01, d); check(d == 16'h0, "R1 reset events", d, 0);
    rd(8'h05, d); check(d == 16'h0, "R1 reset rx count", d, 0);
    wr(8'h02, 16'h0035); rd(8'h02, d); check(d == 16'h0035, "R1 mask readback", d, 16'h35);
    wr(8'h7f, 16'h00a5); rd(8'h7f, d); check(d == 16'h00a5, "R1 tx buffer readback", d, 16'ha5);
    wr(8'h02, 16'h0000);

    // R13: no master bit
    setup_mode(mode_word(0, 0, 0, 0, 1, 0, 1, 4'd7, 4'd0));
    wr(8'h04, 16'd2); wr(8'h03, 16'h0080);
    repeat (60) @(negedge clk);
    rd(8'h01, d); check(d == 16'h0 && edge_n == 0, "R13 start ignored without master", d, 0);

    // directed transfers
    do_xfer(0, 0, 0, 0, 1, 4'd7, 4'd0, 4, 0);
    do_xfer(0, 1, 1, 0, 0, 4'd7, 4'd2, 3, 0);
    do_xfer(1, 0, 1, 1, 1, 4'd4, 4'd0, 2, 0);
    do_xfer(0, 1, 0, 0, 0, 4'd12, 4'd1, 2, 0);
    do_xfer(0, 0, 0, 0, 1, 4'd0, 4'd0, 3, 0);
    do_xfer(0, 0, 1, 0, 1, 4'd7, 4'd0, 64, 0);
    do_xfer(0, 0, 0, 0, 1, 4'd7, 4'd1, 4, 1);
    miso_inv = 0; miso_const = 1;
    do_xfer(0, 0, 0, 0, 1, 4'd5, 4'd0, 2, 0);
    miso_inv = 1;

    // R10: mask and write-one-to-clear
    wr(8'h02, 16'h0001); @(negedge clk);
    check(irq == 1'b1, "R10 irq from masked RXB", irq, 1);
    wr(8'h02, 16'h0010); @(negedge clk);
    check(irq == 1'b0, "R10 irq low when unmasked", irq, 0);
    wr(8'h02, 16'h0001); wr(8'h01, 16'h0001); @(negedge clk);
    check(irq == 1'b0, "R10 irq low after clear", irq, 0);
    rd(8'h01, d); check(d == 16'h0002, "R10 other event kept", d, 2);
    wr(8'h02, 16'h0000);

    // R9: count too large, and count zero
    wr(8'h01, 16'h003f); edge_n = 0;
    wr(8'h04, 16'd65); wr(8'h03, 16'h0080);
    repeat (40) @(negedge clk);
    rd(8'h01, d); check(d == 16'h0010 && edge_n == 0, "R9 oversize count error", d, 16'h10);
    wr(8'h01, 16'h003f);
    wr(8'h04, 16'd0); wr(8'h03, 16'h0080);
    repeat (4) @(negedge clk);
    rd(8'h01, d); check(d == 16'h0003, "R9 empty transfer events", d, 3);
    rd(8'h05, d); check(d == 16'h0, "R9 empty transfer count", d, 0);

    // R11: abort by enable clear
    setup_mode(mode_word(0, 1, 0, 0, 1, 1, 1, 4'd7, 4'd3));
    wr(8'h01, 16'h003f);
    wr(8'h04, 16'd8); wr(8'h03, 16'h0080);
    repeat (150) @(negedge clk);
    wr(8'h00, mode_word(0, 1, 0, 0, 1, 1, 0, 4'd7, 4'd3));
    @(negedge clk);
    check(sck == 1'b1, "R11 SCK idle after abort", sck, 1);
    repeat (600) @(negedge clk);
    rd(8'h01, d); check(d[0] == 1'b0, "R11 no completion after abort", d, 0);
    rd(8'h05, d); check(d > 0 && d < 8, "R11 partial count", d, 2);
    do_xfer(0, 0, 0, 0, 1, 4'd7, 4'd0, 3, 0);

    // R12: multimaster conflict
    setup_mode(mode_word(0, 0, 0, 0, 1, 1, 1, 4'd7, 4'd3));
    wr(8'h01, 16'h003f);
    wr(8'h04, 16'd6); wr(8'h03, 16'h0080);
    repeat (100) @(negedge clk);
    ss_n = 0; repeat (3) @(negedge clk); ss_n = 1;
    repeat (800) @(negedge clk);
    rd(8'h01, d);
    check(d[5] == 1'b1 && d[0] == 1'b0, "R12 conflict event and abort", d, 16'h20);
    check(sck == 1'b0, "R12 SCK idle", sck, 0);

    // random mix
    for (int t = 0; t < 10; t++) begin
      bit dv = ($urandom_range(0, 3) == 0);
      miso_inv = 1;
      do_xfer(1'($urandom), 1'($urandom), 1'($urandom), dv, 1'($urandom),
              4'($urandom), dv ? 4'($urandom_range(0, 1)) : 4'($urandom_range(0, 3)),
              $urandom_range(1, 8), 0);
    end

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule